// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address stream for one SDRAM read or write burst. A memory controller pulses `start_i` together with the column command; on that cycle the block samples the burst fields of the programmed mode word, the 8-bit start column and the direction of the access. From the next clock on it presents one column per cycle on `col_o`, qualified by `valid_o`, and marks the final beat of a finite burst with `last_o`.

The mode word carries a 3-bit length code, a bit that picks the wrap ordering, and a bit that forces every write to a single access. Finite bursts wrap inside the aligned block their length spans. The full-page length runs through all 256 columns, modulo 256, and keeps going until `abort_i` ends it. Codes that the mode word does not define, including full page with interleaved ordering, give a flagged single-beat access. A new `start_i` terminates any running burst and begins the new one at once.

Top module: `burst_colgen`

## Requirements
- R1: After reset is released, and before any start strobe, `valid_o`, `last_o` and `err_o` are 0 and `col_o` is 0.
- R2: The first beat appears on the clock after `start_i` is sampled high: `valid_o` is 1 and `col_o` equals the sampled `col_i`.
- R3: Length code `mode_i[2:0]` gives 1 beat for 000, 2 for 001, 4 for 010 and 8 for 011. `last_o` is 1 on the final beat only, and `valid_o` is 0 on the following clock.
- R4: With `mode_i[3]`=0 (sequential), beat i is the start column with its low log2(L) bits replaced by (start + i) mod L, so the upper bits stay fixed.
- R5: With `mode_i[3]`=1 (interleaved), beat i is the start column XOR i, where i < L.
- R6: Length code 111 with `mode_i[3]`=0 is a full-page burst: beat i is (start + i) mod 256, `last_o` stays 0, and the burst carries on past 256 beats until aborted.
- R7: Length codes 100, 101, 110, and 111 with `mode_i[3]`=1, are reserved: the access is one beat with `last_o`=1 and `err_o`=1 on that beat; `err_o` is 0 whenever `valid_o` is 0.
- R8: With `mode_i[4]`=1, a burst started with `is_write_i`=1 is one beat with `last_o`=1, while a burst started with `is_write_i`=0 has its full coded length.
- R9: When `abort_i` is sampled high during a beat and `start_i` is low, `valid_o`, `last_o` and `err_o` are 0 on the next clock.
- R10: A `start_i` sampled during a running burst, even with `abort_i` high in the same cycle, begins the new burst on the next clock with the new mode, column and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Column command strobe; samples mode, column and direction |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| mode_i | input | 5 | [2:0] length code, [3] ordering (1 interleaved), [4] single-beat writes |
| col_i | input | 8 | Start column address |
| abort_i | input | 1 | Ends the running burst after the current beat |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | The running access came from a reserved code |

## Verification
Termination and restart can fall on the same clock: a new column command arriving while a burst is still running may come with `abort_i` high as well. The bench provokes this in the middle of an 8-beat sequential burst by raising `start_i` and `abort_i` together with an interleaved 4-beat mode and a new column. It judges that the new burst wins: `valid_o` stays high with no gap, and the first beat and all later beats follow the new parameters. Random bursts that abort on the final beat make the abort and the natural end coincide as well.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst fields of the mode word; bit 4 down to bit 0.
  typedef struct packed {
    logic       single_wr;  // [4] writes are single accesses
    logic       order_il;   // [3] 1 = interleaved ordering
    logic [2:0] len_code;   // [2:0] burst length code
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  mode_t            mode,
  input  logic             is_write,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full_page,
  output logic             reserved
);

  always_comb begin
    wrap_mask = '0;
    full_page = 1'b0;
    reserved  = 1'b0;
    case (mode.len_code)
      LEN_1:    wrap_mask = '0;
      LEN_2:    wrap_mask = COL_W'(1);
      LEN_4:    wrap_mask = COL_W'(3);
      LEN_8:    wrap_mask = COL_W'(7);
      LEN_PAGE: begin
        if (mode.order_il) begin
          reserved = 1'b1;
        end else begin
          full_page = 1'b1;
          wrap_mask = '1;
        end
      end
      default:  reserved = 1'b1;
    endcase
    // single-beat writes override the coded length
    if (mode.single_wr && is_write) begin
      wrap_mask = '0;
      full_page = 1'b0;
    end
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             err_i,
  input  logic             inter_i,
  input  logic             abort_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic [COL_W-1:0] base_q, mask_q, idx_q;
  logic             full_q, inter_q;
  logic [COL_W-1:0] idx_n, nxt_col;

  always_comb begin
    idx_n = idx_q + COL_W'(1);
    if (inter_q) nxt_col = base_q ^ (idx_n & mask_q);
    else         nxt_col = (base_q & ~mask_q) | ((base_q + idx_n) & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      idx_q   <= '0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else if (start_i) begin
      base_q  <= col_i;
      mask_q  <= mask_i;
      full_q  <= full_i;
      inter_q <= inter_i;
      idx_q   <= '0;
      col_o   <= col_i;
      valid_o <= 1'b1;
      last_o  <= !full_i && (mask_i == '0);
      err_o   <= err_i;
    end else if (valid_o && (abort_i || last_o)) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else if (valid_o) begin
      idx_q   <= idx_n;
      col_o   <= nxt_col;
      last_o  <= !full_q && (idx_n == mask_q);
    end
  end

  // R3
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R3
  ends_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start_i) |=> !valid_o);

  // R9
  abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && abort_i && !start_i) |=> (!valid_o && !last_o && !err_o));

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(col_i)));

  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (valid_o && last_o));

  // R4
  block_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !abort_i && !start_i && !inter_q)
      |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [4:0]       mode_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             abort_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  mode_t            mode;
  logic [COL_W-1:0] wrap_mask;
  logic             full_page, reserved;

  assign mode = mode_t'(mode_i);

  burst_decode #(.COL_W(COL_W)) u_dec (
    .mode      (mode),
    .is_write  (is_write_i),
    .wrap_mask (wrap_mask),
    .full_page (full_page),
    .reserved  (reserved)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .col_i   (col_i),
    .mask_i  (wrap_mask),
    .full_i  (full_page),
    .err_i   (reserved),
    .inter_i (mode.order_il),
    .abort_i (abort_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .err_o   (err_o)
  );

endmodule

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, is_write_i = 1'b0, abort_i = 1'b0;
  logic [4:0] mode_i = '0;
  logic [7:0] col_i = '0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  burst_colgen u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
    .mode_i(mode_i), .col_i(col_i), .abort_i(abort_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Beats of the access; 0 means full page.
  function automatic int exp_len(input logic [4:0] m, input logic wr);
    if (exp_err(m)) return 1;
    if (m[4] && wr) return 1;
    case (m[2:0])
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err(input logic [4:0] m);
    return (m[2:0] inside {3'd4, 3'd5, 3'd6}) || (m[2:0] == 3'd7 && m[3]);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] base, input int i,
                                         input int len, input bit il);
    logic [7:0] msk;
    logic [7:0] iv;
    iv = 8'(i);
    if (len == 0) return base + iv;
    msk = 8'(len - 1);
    if (il) return base ^ iv;
    return (base & ~msk) | ((base + iv) & msk);
  endfunction

  function automatic string tag_of(input logic [4:0] m, input logic wr);
    if (exp_err(m))                 return "R7";
    if (m[4] && wr)                 return "R8";
    if (exp_len(m, wr) == 0)        return "R6";
    if (m[3])                       return "R5";
    return "R4";
  endfunction

  // Check beats from the current burst on; call at the negedge where
  // beat `first` is on the outputs.
  task automatic follow(input logic [4:0] m, input logic wr, input logic [7:0] col,
                        input int first, input int abort_at);
    int  len;
    bit  er;
    string t;
    len = exp_len(m, wr);
    er  = exp_err(m);
    t   = tag_of(m, wr);
    for (int i = first; i < 400; i++) begin
      if (i > first) @(negedge clk);
      start_i = 1'b0;
      chk(i == 0 ? "R2" : t, "valid", valid_o, 1);
      chk(t, "col", col_o, exp_col(col, i, len, m[3]));
      chk("R3", "last", last_o, (len != 0 && i == len - 1) ? 1 : 0);
      chk("R7", "err", err_o, er ? 1 : 0);
      if (i == abort_at) begin
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk("R9", "valid after abort", valid_o, 0);
        chk("R9", "err after abort", err_o, 0);
        return;
      end
      if (len != 0 && i == len - 1) begin
        @(negedge clk);
        chk("R3", "valid after last", valid_o, 0);
        chk("R7", "err idle", err_o, 0);
        return;
      end
    end
  endtask

  task automatic burst(input logic [4:0] m, input logic wr, input logic [7:0] col,
                       input int abort_at);
    @(negedge clk);
    start_i    = 1'b1;
    mode_i     = m;
    is_write_i = wr;
    col_i      = col;
    @(negedge clk);
    follow(m, wr, col, 0, abort_at);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", valid_o, 0);
    chk("R1", "last", last_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "col", col_o, 0);

    // R3 lengths, sequential (R4)
    burst(5'b00000, 1'b0, 8'h5A, -1);
    burst(5'b00001, 1'b0, 8'h5B, -1);
    burst(5'b00010, 1'b0, 8'h3E, -1);
    burst(5'b00011, 1'b1, 8'hC5, -1);
    // R5 interleaved
    burst(5'b01011, 1'b0, 8'h2D, -1);
    burst(5'b01010, 1'b1, 8'h86, -1);
    // R6 full page wrapping past 256 beats
    burst(5'b00111, 1'b0, 8'hFE, 5);
    burst(5'b00111, 1'b1, 8'h10, 270);
    // R7 reserved codes
    burst(5'b00100, 1'b0, 8'h11, -1);
    burst(5'b00110, 1'b1, 8'h22, -1);
    burst(5'b01111, 1'b0, 8'h33, -1);
    // R8 single-beat writes vs normal reads
    burst(5'b10011, 1'b1, 8'h44, -1);
    burst(5'b10011, 1'b0, 8'h44, -1);
    burst(5'b10111, 1'b1, 8'h47, -1);
    // R9 abort mid burst and on the last beat
    burst(5'b00011, 1'b0, 8'h70, 3);
    burst(5'b01010, 1'b0, 8'h71, 3);

    // R10 start and abort in the same cycle during a burst
    @(negedge clk);
    start_i = 1'b1; mode_i = 5'b00011; is_write_i = 1'b0; col_i = 8'h10;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "first burst col0", col_o, 8'h10);
    @(negedge clk);
    chk("R10", "first burst col1", col_o, 8'h11);
    start_i = 1'b1; abort_i = 1'b1; mode_i = 5'b01010; col_i = 8'h35;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R10", "restart valid", valid_o, 1);
    follow(5'b01010, 1'b0, 8'h35, 0, -1);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [4:0] m;
      logic       wr;
      logic [7:0] c;
      int         ab;
      m  = 5'($urandom_range(0, 31));
      wr = 1'($urandom_range(0, 1));
      c  = 8'($urandom_range(0, 255));
      if (exp_len(m, wr) == 0) ab = $urandom_range(0, 300);
      else if ($urandom_range(0, 3) == 0) ab = $urandom_range(0, 7);
      else ab = -1;
      burst(m, wr, c, ab);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule